// File: doc/BRIEF.md
# Multiplexed Three-Decade BCD Event Counter

This block counts falling edges on an event input into three decimal decades (units, tens, hundreds) that advance together on the same event. A carry ripples through the decades logically but not in time: units, tens and hundreds all update on one counting step. The count can be frozen into a set of per-digit holding registers while counting carries on behind them.

The displayed digits leave the block one at a time on a shared 4-bit BCD bus. Active-low digit strobes mark which decade is on the bus, and a synchronous scan tick steps the selection. An overflow pulse marks each wrap from 999 to 000 so that several counters can be chained into a longer one.

The event input is treated as asynchronous. It is sampled with the system clock, and a falling edge is recognised when a high sample is followed by a low one.

Top module: `bcd3_scan_counter`

## Requirements
- R1: While and after a synchronous reset the count is 000, the strobes select the units digit (digit_sel_n = 3'b110) and ovf is low.
- R2: Each high-to-low transition of evt_in while evt_inhibit is low adds exactly one to the count. A low-to-high transition never changes it.
- R3: The decades are decimal and synchronous: 9 in a decade rolls to 0 and increments the next decade on the same step (for example 099 becomes 100).
- R4: A step from 999 gives 000, and ovf is high for exactly one clock cycle for each such wrap. No other step raises ovf.
- R5: A falling edge of evt_in that arrives while evt_inhibit is high leaves the count unchanged.
- R6: While hold is low the bus shows the live count. While hold is high the bus shows the count captured before hold rose, even though counting continues. When hold drops, the bus returns to the live count.
- R7: digit_sel_n is active-low one-hot. Bit 0 selects units, bit 1 tens and bit 2 hundreds. Each scan_tick cycle moves the selection units→tens→hundreds→units, and without a tick the selection stays where it is.
- R8: digit_out carries the 4-bit BCD value of the digit whose strobe is low.
- R9: A reset applied mid-scan returns the selection to units and clears the count and the holding registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| evt_in | input | 1 | Event input, counted on its falling edges |
| evt_inhibit | input | 1 | High blocks counting |
| hold | input | 1 | High freezes the displayed digits |
| scan_tick | input | 1 | One-cycle pulse that advances the digit scan |
| digit_out | output | 4 | BCD value of the selected digit |
| digit_sel_n | output | 3 | Active-low one-hot digit strobes |
| ovf | output | 1 | One-cycle pulse on a 999→000 wrap |

## Verification
The bench drives the counter through 999 steps to reach the wrap. A design with a broken carry chain shows 090 or 000 where 100 is expected, and a design that mishandles the wrap either misses the ovf pulse or stretches it. It also applies falling edges under inhibit, which a design ignoring the inhibit would count. It raises hold and keeps counting: a design whose holding registers stay transparent would show the live value on the bus. It also issues resets while the scan sits on tens or hundreds, where a design that does not reset the scan position would come back with the wrong strobe active.

// File: rtl/bcd3_pkg.sv
package bcd3_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t value;
        logic carry;
    } decade_step_t;

    // Increment a decimal digit, reporting the roll from 9 to 0.
    function automatic decade_step_t bcd_step(input bcd_t d);
        decade_step_t r;
        if (d >= bcd_t'(9)) begin
            r.value = '0;
            r.carry = 1'b1;
        end else begin
            r.value = d + bcd_t'(1);
            r.carry = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/evt_fall_detect.sv
module evt_fall_detect (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);
    logic s_now;
    logic s_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_now  <= 1'b0;
            s_prev <= 1'b0;
        end else begin
            s_now  <= din;
            s_prev <= s_now;
        end
    end

    assign fall = s_prev & ~s_now;
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
    import bcd3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic carry_in,
    output bcd_t value,
    output logic carry_out
);
    decade_step_t nxt;

    always_comb nxt = bcd_step(value);

    assign carry_out = carry_in & nxt.carry;

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (step && carry_in)
            value <= nxt.value;
    end
endmodule

// File: rtl/digit_scanner.sv
module digit_scanner #(
    parameter int NUM_DIGITS = 3,
    localparam int IW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    output logic [IW-1:0]         pos,
    output logic [NUM_DIGITS-1:0] sel_n
);
    always_ff @(posedge clk) begin
        if (rst)
            pos <= '0;
        else if (tick)
            pos <= (pos == IW'(NUM_DIGITS - 1)) ? '0 : pos + IW'(1);
    end

    always_comb begin
        for (int i = 0; i < NUM_DIGITS; i++)
            sel_n[i] = (pos != IW'(i));
    end
endmodule

// File: rtl/bcd3_scan_counter.sv
module bcd3_scan_counter
    import bcd3_pkg::*;
#(
    parameter int NUM_DIGITS = 3,
    localparam int IW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  evt_in,
    input  logic                  evt_inhibit,
    input  logic                  hold,
    input  logic                  scan_tick,
    output logic [DIGIT_W-1:0]    digit_out,
    output logic [NUM_DIGITS-1:0] digit_sel_n,
    output logic                  ovf
);
    logic    evt_fall;
    logic    advance;
    logic [NUM_DIGITS:0] chain;
    bcd_t    live  [NUM_DIGITS];
    bcd_t    held  [NUM_DIGITS];
    bcd_t    shown [NUM_DIGITS];
    logic [IW-1:0] pos;

    evt_fall_detect i_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (evt_in),
        .fall (evt_fall)
    );

    assign advance  = evt_fall & ~evt_inhibit;
    assign chain[0] = 1'b1;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dec
        bcd_decade i_dec (
            .clk       (clk),
            .rst       (rst),
            .step      (advance),
            .carry_in  (chain[g]),
            .value     (live[g]),
            .carry_out (chain[g+1])
        );

        always_ff @(posedge clk) begin
            if (rst)
                held[g] <= '0;
            else if (!hold)
                held[g] <= live[g];
        end

        assign shown[g] = hold ? held[g] : live[g];
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovf <= 1'b0;
        else
            ovf <= advance & chain[NUM_DIGITS];
    end

    digit_scanner #(.NUM_DIGITS(NUM_DIGITS)) i_scan (
        .clk   (clk),
        .rst   (rst),
        .tick  (scan_tick),
        .pos   (pos),
        .sel_n (digit_sel_n)
    );

    always_comb begin
        digit_out = '0;
        for (int i = 0; i < NUM_DIGITS; i++)
            if (pos == IW'(i))
                digit_out = shown[i];
    end
endmodule

// File: rtl/bcd3_scan_checker.sv
module bcd3_scan_checker
    import bcd3_pkg::*;
#(
    parameter int NUM_DIGITS = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  evt_in,
    input logic                  evt_inhibit,
    input logic                  hold,
    input logic                  scan_tick,
    input logic [DIGIT_W-1:0]    digit_out,
    input logic [NUM_DIGITS-1:0] digit_sel_n,
    input logic                  ovf
);
    assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $countones(~digit_sel_n) == 1);

    assert_sel_steady_R7: assert property (@(posedge clk) disable iff (rst)
        !scan_tick |=> $stable(digit_sel_n));

    assert_ovf_single_R4: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !ovf);

    assert_reset_units_R9: assert property (@(posedge clk)
        rst |=> (digit_sel_n == {{(NUM_DIGITS-1){1'b1}}, 1'b0}) && !ovf);

    assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (hold && !scan_tick) |=> (hold -> $stable(digit_out)));

    assert_digit_bcd_R8: assert property (@(posedge clk) disable iff (rst)
        digit_out <= 4'd9);
endmodule

bind bcd3_scan_counter bcd3_scan_checker #(.NUM_DIGITS(NUM_DIGITS)) i_chk (.*);

// File: tb/test_bcd3_scan_counter.sv
module test_bcd3_scan_counter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt_in = 1'b0;
    logic       evt_inhibit = 1'b0;
    logic       hold = 1'b0;
    logic       scan_tick = 1'b0;
    logic [3:0] digit_out;
    logic [2:0] digit_sel_n;
    logic       ovf;

    int checks = 0;
    int errors = 0;
    int exp_count = 0;
    int exp_held = 0;
    int exp_pos = 0;
    int ovf_seen = 0;
    int ovf_expected = 0;
    int ovf_run = 0;
    int ovf_max_run = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd3_scan_counter i_bcd3_scan_counter (
        .clk(clk), .rst(rst), .evt_in(evt_in), .evt_inhibit(evt_inhibit),
        .hold(hold), .scan_tick(scan_tick), .digit_out(digit_out),
        .digit_sel_n(digit_sel_n), .ovf(ovf)
    );

    always @(negedge clk) begin
        if (!rst && ovf) begin
            ovf_seen++;
            ovf_run++;
            if (ovf_run > ovf_max_run) ovf_max_run = ovf_run;
        end else begin
            ovf_run = 0;
        end
    end

    function automatic int digit_of(int v, int p);
        int d = v;
        for (int k = 0; k < p; k++) d = d / 10;
        return d % 10;
    endfunction

    function automatic logic [2:0] sel_of(int p);
        return ~(3'b001 << p);
    endfunction

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_evt(bit inhibit);
        evt_inhibit = inhibit;
        evt_in = 1'b1;
        cycles(3);
        evt_in = 1'b0;
        cycles(3);
        evt_inhibit = 1'b0;
        if (!inhibit) begin
            if (exp_count == 999) ovf_expected++;
            exp_count = (exp_count + 1) % 1000;
        end
        if (!hold) exp_held = exp_count;
    endtask

    task automatic tick();
        scan_tick = 1'b1;
        cycles(1);
        scan_tick = 1'b0;
        exp_pos = (exp_pos + 1) % 3;
    endtask

    task automatic set_hold(bit h);
        hold = h;
        cycles(1);
        if (!h) exp_held = exp_count;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        exp_count = 0;
        exp_held = 0;
        exp_pos = 0;
        cycles(1);
    endtask

    // R7 and R8: walk the full scan cycle comparing strobes and digit values
    task automatic check_display(string req);
        int shown_v;
        for (int s = 0; s < 3; s++) begin
            shown_v = hold ? exp_held : exp_count;
            check({req, "/R7 sel"}, int'(digit_sel_n), int'(sel_of(exp_pos)));
            check({req, "/R8 digit"}, int'(digit_out), digit_of(shown_v, exp_pos));
            tick();
        end
    endtask

    initial begin
        void'($urandom(32'd5417));
        cycles(3);
        // R1: state during reset
        check("R1 sel in reset", int'(digit_sel_n), 6);
        check("R1 ovf in reset", int'(ovf), 0);
        rst = 1'b0;
        cycles(1);
        check("R1 digit after reset", int'(digit_out), 0);
        check_display("R1");

        // R2: single steps, rising edge alone does nothing
        evt_in = 1'b1;
        cycles(4);
        check("R2 rising edge no count", int'(digit_out), digit_of(exp_count, exp_pos));
        evt_in = 1'b0;
        cycles(3);
        exp_count = 1;
        exp_held = 1;
        check_display("R2");
        for (int i = 0; i < 8; i++) pulse_evt(1'b0);
        check_display("R2 nine");

        // R3: carry 9 -> 10 and 99 -> 100
        pulse_evt(1'b0);
        check_display("R3 ten");
        while (exp_count != 99) pulse_evt(1'b0);
        pulse_evt(1'b0);
        check_display("R3 hundred");

        // R5: inhibit blocks falling edges
        pulse_evt(1'b1);
        pulse_evt(1'b1);
        check_display("R5");

        // R6: hold freezes display while counting continues
        set_hold(1'b1);
        for (int i = 0; i < 15; i++) pulse_evt(1'b0);
        check_display("R6 frozen");
        set_hold(1'b0);
        check_display("R6 live");

        // R4: wrap at 999 with a single-cycle overflow
        while (exp_count != 998) pulse_evt(1'b0);
        check_display("R4 998");
        pulse_evt(1'b0);
        check("R4 no ovf before wrap", ovf_seen, ovf_expected);
        pulse_evt(1'b0);
        check_display("R4 wrap");
        check("R4 ovf count", ovf_seen, ovf_expected);
        check("R4 ovf width", ovf_max_run, 1);

        // R9: reset while scan sits on hundreds
        pulse_evt(1'b0);
        tick();
        tick();
        check("R9 pre-reset pos", int'(digit_sel_n), int'(sel_of(2)));
        do_reset();
        check("R9 sel units", int'(digit_sel_n), 6);
        check("R9 digit cleared", int'(digit_out), 0);
        check_display("R9");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom_range(0, 9));
            if (op <= 4)      pulse_evt(1'b0);
            else if (op == 5) pulse_evt(1'b1);
            else if (op == 6) set_hold(~hold);
            else if (op == 7) tick();
            else if (op == 8) check_display("R6 random");
            else if ($urandom_range(0, 7) == 0) do_reset();
            else begin
                int shown_v = hold ? exp_held : exp_count;
                check("R8 random", int'(digit_out), digit_of(shown_v, exp_pos));
            end
        end
        set_hold(1'b0);
        check_display("R2 random end");
        check("R4 ovf total", ovf_seen, ovf_expected);
        check("R4 ovf width total", ovf_max_run <= 1 ? 1 : 0, 1);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule